// File: doc/BRIEF.md
# Power domain switch sequencer

This block turns one switchable power domain on or off when a request arrives. It drives the domain's power-switch (sleep) control, the isolation control on the domain's outputs, and the memory power-down bits that belong to the domain. It also drives an active-high reset for the domain's logic and a clock enable. The two directions run in different orders. Powering down opens the switch, then puts the memories to sleep, then isolates the outputs, and finally gates the clocks. Powering up closes the switch, then wakes the memories, and only then releases isolation, which it does while the domain logic is held in a reset pulse. After that the clocks come back.

The waits between steps are counted in clock cycles and set through parameters. A short wait separates the switch, memory and isolation steps, and a long wait comes before the clock enable drops. A domain with no switch, which has memories only, runs the same step order with the same waits, but its sleep and isolation outputs stay low. The memory controls share a wider register with other domains. The block therefore forces only the bits selected by a mask parameter, and every other bit passes through unchanged from an input that carries the current register contents.

A controller raises `req_i` for one cycle and gives the target state on `req_on_i`. It then waits for the one-cycle `done_o`, while `pwr_on_o` reports whether the domain is on, taken from the sleep control.

Top module: `pwr_dom_seq`

## Requirements
- R1: With START_OFF=0, after reset the outputs are: `sleep_o`=0, `iso_o`=0, all masked bits of `mem_pd_o` at 0, `rst_dom_o`=0, `clk_en_o`=1, `pwr_on_o`=1, `busy_o`=0 and `done_o`=0.
- R2: An off request is accepted on the clock edge where it is seen while idle. Three outputs then change on the following edges:
  - `sleep_o` rises on that acceptance edge.
  - The masked memory bits go high T_SHORT edges after the acceptance edge.
  - `iso_o` rises T_SHORT edges after the memory bits.
- R3: When HAS_CLK=1, `clk_en_o` falls T_LONG edges after `iso_o` rises, and `done_o` is high in the cycle that follows that edge. When HAS_CLK=0, `done_o` comes on the isolation edge and `clk_en_o` stays 0.
- R4: An on request runs these steps in order:
  - `sleep_o` falls on the acceptance edge.
  - T_SHORT edges later, the masked memory bits clear.
  - T_SHORT edges after that, `rst_dom_o` rises.
  - On the next edge, `iso_o` falls.
  - On the edge after that, `rst_dom_o` falls.
  - On the edge after that, `clk_en_o` rises, together with `done_o`.
- R5: Each bit of `mem_pd_o` set in MEM_MASK reads 1 while the domain's memories are down and 0 while they are up. Each bit not in MEM_MASK always equals the same bit of `mem_base_i`.
- R6: `pwr_on_o` is 1 exactly when the sleep control is 0.
- R7: `done_o` is a single-cycle pulse, given once for each accepted request. `busy_o` is high from the acceptance edge until the edge that raises `done_o`.
- R8: A request for the state the domain is already in raises `done_o` for one cycle right after the acceptance edge, changes no other output, and keeps `busy_o` low.
- R9: A request seen while `busy_o` is high is dropped. The running sequence keeps its timing, and no second sequence follows it.
- R10: With HAS_SWITCH=0, `sleep_o` and `iso_o` stay at 0. The waits and the memory-bit updates keep the timing of R2, and `pwr_on_o` follows the last completed request.
- R11: With START_OFF=1, after reset `sleep_o`=1, `iso_o`=1, all masked memory bits are 1, `clk_en_o`=0 and `pwr_on_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken only while idle |
| req_on_i | input | 1 | Target state of the request: 1 = on, 0 = off |
| mem_base_i | input | MEM_W | Current contents of the shared memory power-down register |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| pwr_on_o | output | 1 | Domain status, 1 = on |
| sleep_o | output | 1 | Power-switch control, 1 = switched off |
| iso_o | output | 1 | Output isolation, 1 = isolated |
| mem_pd_o | output | MEM_W | Memory power-down register value, with masked bits forced |
| rst_dom_o | output | 1 | Domain reset, active high |
| clk_en_o | output | 1 | Domain clock enable |

## Verification
Off and on requests are applied alternately, each against a different pattern on `mem_base_i`: all zeros, all ones, and two mixed values. For each request the bench records the cycle in which every control output changes. These change points show whether each wait is counted correctly and whether the off order and the on order are kept apart. The mixed base patterns show whether bits outside the mask are touched.

Three cases separate a sequence that moves from one that should not:
- a request for the state already in place;
- a second request issued partway through a sequence;
- a memory-only instance, where the switch and isolation outputs must never move.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

   typedef enum logic [3:0] {
      PS_IDLE,
      PS_OFF_W1,
      PS_OFF_W2,
      PS_OFF_WCLK,
      PS_ON_W1,
      PS_ON_W2,
      PS_ON_ISO,
      PS_ON_REL,
      PS_ON_CLK
   } pd_state_e;

endpackage

// File: rtl/pd_seq_timer.sv
module pd_seq_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pd_seq_memmerge.sv
module pd_seq_memmerge #(
   parameter int             MEM_W    = 32,
   parameter logic [MEM_W-1:0] MEM_MASK = '1
) (
   input  logic [MEM_W-1:0] base_i,
   input  logic             down_i,
   output logic [MEM_W-1:0] merged_o
);

   for (genvar i = 0; i < MEM_W; i++) begin : g_bit
      assign merged_o[i] = MEM_MASK[i] ? down_i : base_i[i];
   end

endmodule

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl
   import pd_seq_pkg::*;
#(
   parameter int T_SHORT   = 4,
   parameter int T_LONG    = 10,
   parameter bit HAS_CLK   = 1'b1,
   parameter bit START_OFF = 1'b0,
   parameter int CW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          req_on_i,
   input  logic          tmr_zero_i,
   output logic          tmr_load_o,
   output logic [CW-1:0] tmr_val_o,
   output logic          slp_o,
   output logic          iso_o,
   output logic          mem_dn_o,
   output logic          rst_dom_o,
   output logic          clk_en_o,
   output logic          busy_o,
   output logic          done_o
);

   localparam logic [CW-1:0] SHORT_LD = CW'(T_SHORT - 1);
   localparam logic [CW-1:0] LONG_LD  = CW'(T_LONG - 1);

   pd_state_e st_q, st_d;
   logic slp_q, slp_d, iso_q, iso_d, mem_q, mem_d;
   logic rsd_q, rsd_d, clk_q, clk_d, done_q, done_d;

   always_comb begin
      st_d       = st_q;
      slp_d      = slp_q;
      iso_d      = iso_q;
      mem_d      = mem_q;
      rsd_d      = rsd_q;
      clk_d      = clk_q;
      done_d     = 1'b0;
      tmr_load_o = 1'b0;
      tmr_val_o  = SHORT_LD;
      unique case (st_q)
         PS_IDLE: begin
            if (req_i) begin
               if (req_on_i != slp_q) begin
                  done_d = 1'b1;
               end else if (req_on_i) begin
                  slp_d      = 1'b0;
                  st_d       = PS_ON_W1;
                  tmr_load_o = 1'b1;
               end else begin
                  slp_d      = 1'b1;
                  st_d       = PS_OFF_W1;
                  tmr_load_o = 1'b1;
               end
            end
         end
         PS_OFF_W1: begin
            if (tmr_zero_i) begin
               mem_d      = 1'b1;
               st_d       = PS_OFF_W2;
               tmr_load_o = 1'b1;
            end
         end
         PS_OFF_W2: begin
            if (tmr_zero_i) begin
               iso_d = 1'b1;
               if (HAS_CLK) begin
                  st_d       = PS_OFF_WCLK;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = LONG_LD;
               end else begin
                  st_d   = PS_IDLE;
                  done_d = 1'b1;
               end
            end
         end
         PS_OFF_WCLK: begin
            if (tmr_zero_i) begin
               clk_d  = 1'b0;
               st_d   = PS_IDLE;
               done_d = 1'b1;
            end
         end
         PS_ON_W1: begin
            if (tmr_zero_i) begin
               mem_d      = 1'b0;
               st_d       = PS_ON_W2;
               tmr_load_o = 1'b1;
            end
         end
         PS_ON_W2: begin
            if (tmr_zero_i) begin
               rsd_d = 1'b1;
               st_d  = PS_ON_ISO;
            end
         end
         PS_ON_ISO: begin
            iso_d = 1'b0;
            st_d  = PS_ON_REL;
         end
         PS_ON_REL: begin
            rsd_d = 1'b0;
            st_d  = PS_ON_CLK;
         end
         PS_ON_CLK: begin
            clk_d  = HAS_CLK;
            st_d   = PS_IDLE;
            done_d = 1'b1;
         end
         default: st_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_IDLE;
         slp_q  <= START_OFF;
         iso_q  <= START_OFF;
         mem_q  <= START_OFF;
         rsd_q  <= 1'b0;
         clk_q  <= HAS_CLK && !START_OFF;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         slp_q  <= slp_d;
         iso_q  <= iso_d;
         mem_q  <= mem_d;
         rsd_q  <= rsd_d;
         clk_q  <= clk_d;
         done_q <= done_d;
      end
   end

   assign slp_o     = slp_q;
   assign iso_o     = iso_q;
   assign mem_dn_o  = mem_q;
   assign rst_dom_o = rsd_q;
   assign clk_en_o  = clk_q;
   assign busy_o    = (st_q != PS_IDLE);
   assign done_o    = done_q;

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
   parameter int               MEM_W      = 32,
   parameter logic [MEM_W-1:0] MEM_MASK   = 32'h0000_FF0C,
   parameter int               T_SHORT    = 4,
   parameter int               T_LONG     = 10,
   parameter bit               HAS_SWITCH = 1'b1,
   parameter bit               HAS_CLK    = 1'b1,
   parameter bit               START_OFF  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             req_on_i,
   input  logic [MEM_W-1:0] mem_base_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             pwr_on_o,
   output logic             sleep_o,
   output logic             iso_o,
   output logic [MEM_W-1:0] mem_pd_o,
   output logic             rst_dom_o,
   output logic             clk_en_o
);

   localparam int T_MAX = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
   localparam int CW    = $clog2(T_MAX + 1);

   if (T_SHORT < 1 || T_LONG < 1) begin : g_bad_delay
      $error("pwr_dom_seq: T_SHORT and T_LONG must be at least 1");
   end
   if (MEM_W < 1) begin : g_bad_width
      $error("pwr_dom_seq: MEM_W must be at least 1");
   end

   logic          tmr_load, tmr_zero;
   logic [CW-1:0] tmr_val;
   logic          slp_int, iso_int, mem_dn;

   pd_seq_timer #(.CW(CW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   pd_seq_ctrl #(
      .T_SHORT   (T_SHORT),
      .T_LONG    (T_LONG),
      .HAS_CLK   (HAS_CLK),
      .START_OFF (START_OFF),
      .CW        (CW)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .req_on_i   (req_on_i),
      .tmr_zero_i (tmr_zero),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .slp_o      (slp_int),
      .iso_o      (iso_int),
      .mem_dn_o   (mem_dn),
      .rst_dom_o  (rst_dom_o),
      .clk_en_o   (clk_en_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   pd_seq_memmerge #(.MEM_W(MEM_W), .MEM_MASK(MEM_MASK)) u_merge (
      .base_i   (mem_base_i),
      .down_i   (mem_dn),
      .merged_o (mem_pd_o)
   );

   if (HAS_SWITCH) begin : g_switch
      assign sleep_o = slp_int;
      assign iso_o   = iso_int;
   end else begin : g_memonly
      logic unused_iso;
      assign unused_iso = iso_int;
      assign sleep_o    = 1'b0;
      assign iso_o      = 1'b0;
   end

   assign pwr_on_o = !slp_int;

endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk #(
   parameter int               MEM_W    = 32,
   parameter logic [MEM_W-1:0] MEM_MASK = '1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             sleep_o,
   input logic             iso_o,
   input logic [MEM_W-1:0] mem_pd_o,
   input logic             rst_dom_o,
   input logic             clk_en_o
);

   // R2
   iso_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_o) |-> sleep_o && ((mem_pd_o & MEM_MASK) == MEM_MASK));

   // R4
   iso_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_o) |-> rst_dom_o);

   // R4
   rst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_dom_o) |-> !sleep_o && ((mem_pd_o & MEM_MASK) == '0));

   // R3
   clk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_o) |-> done_o && ((mem_pd_o & MEM_MASK) == MEM_MASK));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !req_i |=> !done_o);

   // R7
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

endmodule

bind pwr_dom_seq pwr_dom_seq_chk #(.MEM_W(MEM_W), .MEM_MASK(MEM_MASK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .sleep_o   (sleep_o),
   .iso_o     (iso_o),
   .mem_pd_o  (mem_pd_o),
   .rst_dom_o (rst_dom_o),
   .clk_en_o  (clk_en_o)
);

// File: tb/pwr_dom_seq_bench.sv
module pwr_dom_seq_bench;

   localparam int          TS   = 4;
   localparam int          TL   = 10;
   localparam logic [31:0] MASK = 32'h0000_FF0C;

   // Each entry: {req_on, mem_base}
   localparam logic [32:0] VEC [4] = '{
      {1'b0, 32'h0000_0000},
      {1'b1, 32'hFFFF_FFFF},
      {1'b0, 32'hA5A5_A5A5},
      {1'b1, 32'h3C3C_00F0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic        req = 1'b0, req_on = 1'b0;
   logic [31:0] base = '0;
   logic        busy, done, pwr_on, sleep, iso, rstd, clken;
   logic [31:0] mem;

   logic        m_req = 1'b0, m_on = 1'b0;
   logic        m_busy, m_done, m_pwr, m_sleep, m_iso, m_rst, m_clk;
   logic [31:0] m_mem;

   logic        o_busy, o_done, o_pwr, o_sleep, o_iso, o_rst, o_clk;
   logic [31:0] o_mem;

   pwr_dom_seq #(.MEM_W(32), .MEM_MASK(MASK), .T_SHORT(TS), .T_LONG(TL),
      .HAS_SWITCH(1'b1), .HAS_CLK(1'b1), .START_OFF(1'b0)) u_pwr_dom_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_on_i(req_on),
      .mem_base_i(base), .busy_o(busy), .done_o(done), .pwr_on_o(pwr_on),
      .sleep_o(sleep), .iso_o(iso), .mem_pd_o(mem), .rst_dom_o(rstd),
      .clk_en_o(clken));

   pwr_dom_seq #(.MEM_W(32), .MEM_MASK(MASK), .T_SHORT(TS), .T_LONG(TL),
      .HAS_SWITCH(1'b0), .HAS_CLK(1'b0), .START_OFF(1'b0)) u_memonly (
      .clk(clk), .rst_n(rst_n), .req_i(m_req), .req_on_i(m_on),
      .mem_base_i(32'h0), .busy_o(m_busy), .done_o(m_done), .pwr_on_o(m_pwr),
      .sleep_o(m_sleep), .iso_o(m_iso), .mem_pd_o(m_mem), .rst_dom_o(m_rst),
      .clk_en_o(m_clk));

   pwr_dom_seq #(.MEM_W(32), .MEM_MASK(MASK), .T_SHORT(TS), .T_LONG(TL),
      .HAS_SWITCH(1'b1), .HAS_CLK(1'b1), .START_OFF(1'b1)) u_startoff (
      .clk(clk), .rst_n(rst_n), .req_i(1'b0), .req_on_i(1'b0),
      .mem_base_i(32'h0), .busy_o(o_busy), .done_o(o_done), .pwr_on_o(o_pwr),
      .sleep_o(o_sleep), .iso_o(o_iso), .mem_pd_o(o_mem), .rst_dom_o(o_rst),
      .clk_en_o(o_clk));

   // change points recorded by run_req (sample index, 0 = no change)
   int c_sl, c_mem, c_iso, c_rr, c_rf, c_clk, c_done, n_done, busy_cnt;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_req(input logic on, input int extra_at);
      logic p_sl, p_iso, p_rst, p_clk;
      logic [31:0] p_mem;
      @(negedge clk);
      req = 1'b1; req_on = on;
      p_sl = sleep; p_iso = iso; p_rst = rstd; p_clk = clken; p_mem = mem;
      c_sl = 0; c_mem = 0; c_iso = 0; c_rr = 0; c_rf = 0; c_clk = 0;
      c_done = 0; n_done = 0; busy_cnt = 0;
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         req = 1'b0;
         if (k == extra_at) begin
            req = 1'b1; req_on = !on;
         end
         if (sleep != p_sl && c_sl == 0) c_sl = k;
         if (mem != p_mem && c_mem == 0) c_mem = k;
         if (iso != p_iso && c_iso == 0) c_iso = k;
         if (rstd && !p_rst && c_rr == 0) c_rr = k;
         if (!rstd && p_rst && c_rf == 0) c_rf = k;
         if (clken != p_clk && c_clk == 0) c_clk = k;
         if (done) begin
            n_done++;
            if (c_done == 0) c_done = k;
         end
         if (busy) busy_cnt++;
         p_sl = sleep; p_iso = iso; p_rst = rstd; p_clk = clken; p_mem = mem;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, default start
      chk(sleep == 0 && iso == 0 && (mem & MASK) == 0, "R1 controls",
          {sleep, iso, mem}, 0);
      chk(rstd == 0 && clken == 1 && pwr_on == 1 && busy == 0 && done == 0,
          "R1 status", {rstd, clken, pwr_on, busy, done}, 5'b01100);
      // R11 reset state, start-off
      chk(o_sleep && o_iso && (o_mem & MASK) == MASK && !o_clk && !o_pwr,
          "R11 start off", {o_sleep, o_iso, o_clk, o_pwr}, 4'b1100);
      // R3 clock enable stays low without clocks
      chk(m_clk == 0, "R3 no clocks", m_clk, 0);

      // R8 on request while already on
      run_req(1'b1, 0);
      chk(c_done == 1 && n_done == 1, "R8 done at once", c_done, 1);
      chk(c_sl == 0 && c_mem == 0 && c_iso == 0 && c_clk == 0 && c_rr == 0 && busy_cnt == 0,
          "R8 nothing toggled", {c_sl, c_mem, c_iso, c_clk, busy_cnt}, 0);

      // table-driven sequences
      for (int v = 0; v < 4; v++) begin
         logic        on;
         logic [31:0] b, exp_mem;
         on = VEC[v][32];
         b  = VEC[v][31:0];
         base = b;
         run_req(on, 0);
         exp_mem = on ? (b & ~MASK) : ((b & ~MASK) | MASK);
         chk(c_sl == 1, $sformatf("R2/R4 sleep step v%0d", v), c_sl, 1);
         chk(c_mem == TS + 1, $sformatf("R2/R4 memory step v%0d", v), c_mem, TS + 1);
         if (!on) begin
            chk(c_iso == 2*TS + 1, $sformatf("R2 isolation v%0d", v), c_iso, 2*TS + 1);
            chk(c_clk == 2*TS + TL + 1 && c_done == c_clk,
                $sformatf("R3 clock off v%0d", v), c_clk, 2*TS + TL + 1);
            chk(c_rr == 0, $sformatf("R2 no reset v%0d", v), c_rr, 0);
         end else begin
            chk(c_rr == 2*TS + 1, $sformatf("R4 reset assert v%0d", v), c_rr, 2*TS + 1);
            chk(c_iso == 2*TS + 2, $sformatf("R4 isolation v%0d", v), c_iso, 2*TS + 2);
            chk(c_rf == 2*TS + 3, $sformatf("R4 reset release v%0d", v), c_rf, 2*TS + 3);
            chk(c_clk == 2*TS + 4 && c_done == c_clk,
                $sformatf("R4 clock on v%0d", v), c_clk, 2*TS + 4);
         end
         chk(mem == exp_mem, $sformatf("R5 memory word v%0d", v), mem, exp_mem);
         chk(pwr_on == on && sleep == !on, $sformatf("R6 status v%0d", v), pwr_on, on);
         chk(n_done == 1 && busy_cnt == c_done - 1,
             $sformatf("R7 done/busy v%0d", v), {n_done, busy_cnt}, {1, c_done - 1});
      end

      // R9 on request issued mid off sequence is dropped
      base = 32'h0;
      run_req(1'b0, 3);
      chk(c_iso == 2*TS + 1 && c_clk == 2*TS + TL + 1, "R9 timing kept",
          c_clk, 2*TS + TL + 1);
      chk(n_done == 1 && pwr_on == 0 && clken == 0 && c_rr == 0,
          "R9 no second sequence", {n_done, pwr_on, clken}, 4'b0100);

      // R8 off request while already off
      run_req(1'b0, 0);
      chk(c_done == 1 && c_sl == 0 && c_mem == 0 && busy_cnt == 0,
          "R8 off while off", {c_done, c_sl, c_mem}, 1);

      // R10 memory-only domain: off request
      begin
         int mc = 0, md = 0;
         bit moved = 1'b0;
         @(negedge clk);
         m_req = 1'b1; m_on = 1'b0;
         for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            m_req = 1'b0;
            if ((m_mem & MASK) == MASK && mc == 0) mc = k;
            if (m_done && md == 0) md = k;
            if (m_sleep || m_iso) moved = 1'b1;
         end
         chk(mc == TS + 1, "R10 memory step", mc, TS + 1);
         chk(md == 2*TS + 1, "R10 done", md, 2*TS + 1);
         chk(!moved && m_pwr == 0, "R10 switch idle", {moved, m_pwr}, 0);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule